// File: doc/BRIEF.md
# Low-Power Phase Overcurrent Detector

This block watches the three phase-current magnitudes of a metering front end while the rest of the chip sits in a low-power state. Each current sample is compared with a threshold set in eighths of full scale. For each phase, the block counts how many times the current rises across that threshold. An external tick, one pulse every 20 ms, paces a measurement window made of a programmable number of these periods.

When a window closes, the block reads the three counts. If any phase reached the configured event limit, it pulls the "overcurrent" interrupt low. Otherwise it pulls the "quiet" interrupt low. Each interrupt stays low until a clear pulse arrives. Windows follow each other without a gap while the enable input is high. Dropping enable restarts the timer and the counters.

Top module: `lp_overcurrent_det`

## Requirements
- R1: After reset, the configuration readback is 0x07 (threshold code 7 in bits [2:0], window code 0 in bits [7:3]), and both interrupt outputs are high.
- R2: A write strobe loads the 8-bit configuration. The new value is visible on the readback in the next cycle.
- R3: A sample counts as over threshold only when it is strictly greater than threshold code × 2^SAMPLE_W / 8. A sample equal to that value does not count.
- R4: A phase counter increments only on a rising crossing, where a valid sample is over threshold and the previous valid sample of that phase was not. A current that stays over threshold counts once.
- R5: A window closes on the (window code + 1)-th tick after it starts. Neither interrupt changes before that tick.
- R6: When a window closes and every phase count is below window code + 1, the quiet interrupt goes low.
- R7: When a window closes and any phase count is at least window code + 1, the overcurrent interrupt goes low. At most one interrupt is asserted per window.
- R8: Phase counters saturate at CNT_MAX (63) and do not wrap.
- R9: An interrupt stays low until irq_clr is pulsed. The clear releases both lines, unless a new window result is written in the same cycle, which takes priority.
- R10: While enable is low, the counters, the window timer and the crossing history are held at zero.
- R11: Counters restart at zero for each new window, and windows repeat back to back. A crossing in the same cycle as the closing tick counts toward the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the detector; low restarts the window |
| tick | input | 1 | One-cycle pulse every 20 ms |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_q | output | 8 | Configuration readback |
| smp_valid | input | 1 | The three samples are valid this cycle |
| smp_a | input | SAMPLE_W | Phase A current magnitude |
| smp_b | input | SAMPLE_W | Phase B current magnitude |
| smp_c | input | SAMPLE_W | Phase C current magnitude |
| irq_clr | input | 1 | Releases both interrupt lines |
| irq0_n | output | 1 | Active-low quiet-window interrupt |
| irq1_n | output | 1 | Active-low overcurrent interrupt |

## Verification
The bound checker enforces the following on every cycle:
- an interrupt falls only on a window-closing tick, and the two interrupts never fall together;
- an interrupt stays low until it is cleared, and a clear releases both lines;
- a counter moves by at most one per cycle and holds at saturation;
- disabling the block empties the counters and the timer.

The directed scenarios cover the rest:
- the exact threshold boundary and the rising-crossing rule;
- the window length for several codes, and which interrupt a given set of per-phase counts selects;
- the worked 60 ms example;
- saturation observed through a 32-event limit;
- where a crossing lands when it coincides with the closing tick.

// File: rtl/lp_overcurrent_det.sv
module lp_overcurrent_det #(
  parameter int SAMPLE_W = 12,
  parameter int CNT_MAX  = 63
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                tick,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_q,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_a,
  input  logic [SAMPLE_W-1:0] smp_b,
  input  logic [SAMPLE_W-1:0] smp_c,
  input  logic                irq_clr,
  output logic                irq0_n,
  output logic                irq1_n
);
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int NPH   = 3;

  logic [2:0]                     thr_code;
  logic [4:0]                     win_code;
  logic [SAMPLE_W-1:0]            thr;
  logic [NPH-1:0][SAMPLE_W-1:0]   smp;
  logic [NPH-1:0]                 above, prev_q, rise, reach;
  logic [NPH-1:0][CNT_W-1:0]      cnt_q;
  logic [4:0]                     tcnt_q;
  logic                           win_end, hit;

  assign thr_code = cfg_q[2:0];
  assign win_code = cfg_q[7:3];
  assign thr      = SAMPLE_W'(thr_code) << (SAMPLE_W - 3);
  assign smp      = {smp_c, smp_b, smp_a};
  assign win_end  = enable && tick && (tcnt_q >= win_code);

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    assign above[i] = smp[i] > thr;
    assign rise[i]  = smp_valid && above[i] && !prev_q[i];
    assign reach[i] = int'(cnt_q[i]) >= int'(win_code) + 1;
  end
  assign hit = |reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= 8'h07;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else if (!enable || win_end) tcnt_q <= '0;
    else if (tick) tcnt_q <= tcnt_q + 5'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else if (!enable) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (smp_valid) prev_q <= above;
      for (int i = 0; i < NPH; i++) begin
        if (rise[i]) begin
          if (win_end) cnt_q[i] <= CNT_W'(1);
          else if (int'(cnt_q[i]) < CNT_MAX) cnt_q[i] <= cnt_q[i] + CNT_W'(1);
        end else if (win_end) begin
          cnt_q[i] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_n <= 1'b1;
      irq1_n <= 1'b1;
    end else begin
      if (irq_clr) begin
        irq0_n <= 1'b1;
        irq1_n <= 1'b1;
      end
      if (win_end) begin
        if (hit) irq1_n <= 1'b0;
        else     irq0_n <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lp_overcurrent_det_chk.sv
module lp_overcurrent_det_chk #(
  parameter int CNT_W   = 6,
  parameter int CNT_MAX = 63
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  enable,
  input logic                  irq_clr,
  input logic                  irq0_n,
  input logic                  irq1_n,
  input logic                  win_end,
  input logic [4:0]            tcnt_q,
  input logic [2:0][CNT_W-1:0] cnt_q
);
  a_r5_irq_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq0_n) || $fell(irq1_n)) |-> $past(win_end));

  a_r7_single_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !($fell(irq0_n) && $fell(irq1_n)));

  a_r9_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !win_end) |=> (irq0_n && irq1_n));

  a_r9_sticky_irq0: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq0_n && !irq_clr) |=> !irq0_n);

  a_r9_sticky_irq1: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq1_n && !irq_clr) |=> !irq1_n);

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0 && tcnt_q == '0));

  for (genvar i = 0; i < 3; i++) begin : g_c
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !win_end && int'(cnt_q[i]) == CNT_MAX) |=> int'(cnt_q[i]) == CNT_MAX);

    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !win_end) |=> ((cnt_q[i] - $past(cnt_q[i])) <= CNT_W'(1)));
  end
endmodule

bind lp_overcurrent_det lp_overcurrent_det_chk #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .irq_clr(irq_clr),
  .irq0_n(irq0_n), .irq1_n(irq1_n), .win_end(win_end),
  .tcnt_q(tcnt_q), .cnt_q(cnt_q)
);

// File: tb/lp_overcurrent_det_bench.sv
module lp_overcurrent_det_bench;
  localparam int SW = 12;
  logic clk = 0, rst_n = 0, enable = 0, tick = 0, cfg_we = 0, smp_valid = 0, irq_clr = 0;
  logic [7:0] cfg_wdata = 0, cfg_q;
  logic [SW-1:0] smp_a = 0, smp_b = 0, smp_c = 0;
  logic irq0_n, irq1_n;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  lp_overcurrent_det #(.SAMPLE_W(SW)) u_lp_overcurrent_det (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .smp_valid(smp_valid), .smp_a(smp_a),
    .smp_b(smp_b), .smp_c(smp_c), .irq_clr(irq_clr), .irq0_n(irq0_n), .irq1_n(irq1_n));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic irqs(input string req, input bit e0, input bit e1);
    chk(irq0_n == e0, {req, " irq0_n"}, irq0_n, e0);
    chk(irq1_n == e1, {req, " irq1_n"}, irq1_n, e1);
  endtask

  task automatic smp(input int a, input int b, input int c, input bit t = 0);
    smp_valid = 1; smp_a = SW'(a); smp_b = SW'(b); smp_c = SW'(c); tick = t;
    @(negedge clk);
    smp_valid = 0; tick = 0;
  endtask

  task automatic tk(input int n = 1);
    for (int k = 0; k < n; k++) begin
      tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  task automatic wcfg(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v; @(negedge clk); cfg_we = 0;
  endtask

  task automatic clr();
    irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  task automatic restart(input logic [7:0] v);
    clr(); wcfg(v);
    enable = 0; @(negedge clk); enable = 1;
  endtask

  task automatic cross_a(); smp(2000, 0, 0); smp(0, 0, 0); endtask

  task automatic t_reset();
    chk(cfg_q == 8'h07, "R1 cfg reset", cfg_q, 8'h07);
    irqs("R1", 1, 1);
  endtask

  task automatic t_example();
    restart(8'h13);
    chk(cfg_q == 8'h13, "R2 cfg write", cfg_q, 8'h13);
    cross_a(); cross_a(); cross_a();
    tk(2);
    irqs("R5 early", 1, 1);
    tk(1);
    irqs("R7 example", 1, 0);
    clr();
    irqs("R9 clear", 1, 1);
    tk(3);
    irqs("R11 next window empty / R6", 0, 1);
  endtask

  task automatic t_threshold();
    restart(8'h03);
    smp(1536, 1536, 1536); smp(0, 0, 0);
    tk(1);
    irqs("R3 equal not over", 0, 1);
    clr();
    smp(0, 1537, 0); smp(0, 0, 0);
    tk(1);
    irqs("R3 one above", 1, 0);
  endtask

  task automatic t_rising();
    restart(8'h0B);
    smp(2000, 0, 0); smp(2000, 0, 0); smp(3000, 0, 0);
    tk(2);
    irqs("R4 held counts once", 0, 1);
    clr();
    smp(0, 0, 0); smp(2000, 0, 0); smp(0, 0, 0); smp(2000, 0, 0);
    tk(2);
    irqs("R4 two crossings", 1, 0);
  endtask

  task automatic t_perphase();
    restart(8'h0B);
    smp(2000, 0, 0); smp(0, 2000, 0); smp(0, 0, 0);
    tk(2);
    irqs("R6 per-phase below", 0, 1);
  endtask

  task automatic t_saturate();
    restart(8'hFB);
    for (int k = 0; k < 64; k++) begin smp(0, 0, 4000); smp(0, 0, 0); end
    tk(31);
    irqs("R8 before end", 1, 1);
    tk(1);
    irqs("R8 saturate no wrap", 1, 0);
  endtask

  task automatic t_disable();
    restart(8'h0B);
    cross_a(); tk(1);
    enable = 0; @(negedge clk); enable = 1;
    cross_a(); tk(1);
    irqs("R10 timer restarted", 1, 1);
    tk(1);
    irqs("R10 counters cleared", 0, 1);
  endtask

  task automatic t_sticky();
    restart(8'h03);
    tk(1);
    irqs("R6 quiet", 0, 1);
    cross_a(); tk(1);
    irqs("R9 both held", 0, 0);
    repeat (3) @(negedge clk);
    irqs("R9 still held", 0, 0);
    clr();
    irqs("R9 released", 1, 1);
  endtask

  task automatic t_endcycle();
    restart(8'h03);
    smp(2000, 0, 0, 1);
    irqs("R11 end-cycle event excluded", 0, 1);
    clr();
    smp(0, 0, 0); tk(1);
    irqs("R11 event in next window", 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    enable = 1;
    t_example();
    t_threshold();
    t_rising();
    t_perphase();
    t_saturate();
    t_disable();
    t_sticky();
    t_endcycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule